// File: doc/BRIEF.md
# Four-Bank GPIO Controller with Edge-Detect Interrupts

This block is a memory-mapped general-purpose I/O controller for up to 128 pins, arranged as four banks of 32. Each pin has a direction bit and an output latch. Software never writes the latch directly. It ORs bits in through a set register and removes them through a clear register, so separate agents can drive separate pins without a read-modify-write. Pin inputs pass through a two-flop synchroniser. A rising or falling transition on an input pin can be latched into a per-bank edge-status register. Software acknowledges a latched edge by writing 1s to that register.

The latched status drives three level interrupts:
- one for pin 0 alone;
- one for pin 1 alone;
- one shared line for every other pin.

A one-cycle wake pulse marks activity on a fixed set of input pins. Two alternate-function registers per bank hold values that software can read back; they have no effect inside the block. The register bus is a single-cycle select/write strobe. Read data is registered and appears in the cycle after the request.

Only the first `NUM_LINES` pins exist. Pins above that count never drive an output and never record an edge.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: On reset every register, the read data, all pin outputs and output-enables, all three interrupts and the wake pulse are 0.
- R2: Each bank has a direction register (bank offsets 0x00C, 0x010, 0x014, 0x10C; bit = 1 means output). It reads back as written. `pin_oe` of each implemented pin equals its direction bit.
- R3: Writing the set register (0x018, 0x01C, 0x020, 0x118) ORs the data into the output latch. Writing the clear register (0x024, 0x028, 0x02C, 0x124) clears each latch bit written with 1. `pin_out` of each implemented pin is its latch bit ANDed with its direction bit.
- R4: The level register (0x000, 0x004, 0x008, 0x100) returns the latch bit for output pins and the synchronised input for input pins. Writes to it are ignored.
- R5: A status bit is set only for an implemented input-direction pin whose synchronised value rises with its rising-enable bit set, or falls with its falling-enable bit set. Rising-enable is at 0x030, 0x034, 0x038, 0x130 and falling-enable at 0x03C, 0x040, 0x044, 0x13C. A pin change is visible in status after the third rising clock edge that follows it.
- R6: Writing the status register (0x048, 0x04C, 0x050, 0x148) clears each bit written with 1. Bits otherwise stay set. An edge detected in the same cycle as a clear of that bit leaves it set.
- R7: `irq_pin0` equals bank 0 status bit 0 and `irq_pin1` equals bank 0 status bit 1.
- R8: `irq_other` is the OR of bank 0 status bits 2 to 31 and every status bit of banks 1 to 3.
- R9: `wake_pulse` is high for one cycle, aligned with status capture, when an implemented input-direction pin in the wake mask changes. The per-bank masks are 0x8003FE1B, 0x002001FC, 0xEC080000 and 0x0012007F.
- R10: Each bank has low and high alternate-function registers: low at 0x054, 0x05C, 0x064, 0x06C and high at 0x058, 0x060, 0x068, 0x070. They are plain read/write storage.
- R11: Address decoding has these fixed results:
  - The set register reads back the last value written to it.
  - The clear register reads 0.
  - Unmapped offsets below 0x200 read 0 and ignore writes.
  - Offsets of 0x200 and above read 0 and ignore writes.
- R12: Pins with index `NUM_LINES` or above drive 0 on `pin_out` and `pin_oe`, never set status, and read 0 as inputs.
- R13: `bus_rdata` holds the read result in the cycle after a read request and is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 128 | Asynchronous pin inputs |
| pin_out | output | 128 | Pin output values |
| pin_oe | output | 128 | Pin output enables |
| irq_pin0 | output | 1 | Interrupt for pin 0 |
| irq_pin1 | output | 1 | Interrupt for pin 1 |
| irq_other | output | 1 | Aggregate interrupt for the remaining pins |
| wake_pulse | output | 1 | One-cycle wake request |

## Verification
The bench builds the controller with `NUM_LINES` = 100, so bank 3 holds both implemented and missing pins. This makes the gating of outputs, status and input reads on absent pins observable next to live ones in the same register.

`ADDR_W` stays at 12, so offsets above 0x200 and aliases of valid offsets (such as 0x218) can be addressed. A cycle-level reference model predicts every output each cycle. Directed phases cover each register kind, and a long random phase mixes bus traffic with pin toggles to reach clears that coincide with edges.

// File: rtl/gpio_ctl_pkg.sv
package gpio_ctl_pkg;

    localparam int NBANK = 4;
    localparam int BW    = 32;
    localparam int NPIN  = NBANK * BW;

    typedef enum logic [3:0] {
        RK_NONE  = 4'd0,
        RK_LEVEL = 4'd1,
        RK_DIR   = 4'd2,
        RK_SET   = 4'd3,
        RK_CLR   = 4'd4,
        RK_RISE  = 4'd5,
        RK_FALL  = 4'd6,
        RK_STAT  = 4'd7,
        RK_AFLO  = 4'd8,
        RK_AFHI  = 4'd9
    } reg_kind_e;

    localparam int NKIND = 10;

    typedef struct packed {
        reg_kind_e   kind;
        logic [1:0]  bank;
    } reg_sel_t;

    typedef struct packed {
        logic [BW-1:0] dir;
        logic [BW-1:0] olat;
        logic [BW-1:0] ren;
        logic [BW-1:0] fen;
        logic [BW-1:0] stat;
        logic [BW-1:0] aflo;
        logic [BW-1:0] afhi;
        logic [BW-1:0] lset;
    } bank_view_t;

    // Bank 0 base offset of each per-bank register; banks 0..2 step by 4,
    // bank 3 sits 0x100 above bank 0. Alternate-function registers interleave by 8.
    function automatic logic [11:0] reg_offset(reg_kind_e k, int b);
        logic [11:0] base;
        logic        afr;
        base = 12'h000;
        afr  = 1'b0;
        case (k)
            RK_LEVEL: base = 12'h000;
            RK_DIR:   base = 12'h00C;
            RK_SET:   base = 12'h018;
            RK_CLR:   base = 12'h024;
            RK_RISE:  base = 12'h030;
            RK_FALL:  base = 12'h03C;
            RK_STAT:  base = 12'h048;
            RK_AFLO:  begin base = 12'h054; afr = 1'b1; end
            RK_AFHI:  begin base = 12'h058; afr = 1'b1; end
            default:  base = 12'hFFF;
        endcase
        if (afr)
            return base + 12'(8 * b);
        else if (b == 3)
            return base + 12'h100;
        else
            return base + 12'(4 * b);
    endfunction

    function automatic logic [BW-1:0] wake_mask(int b);
        case (b)
            0:       return 32'h8003_FE1B;
            1:       return 32'h0020_01FC;
            2:       return 32'hEC08_0000;
            default: return 32'h0012_007F;
        endcase
    endfunction

    function automatic logic [BW-1:0] impl_mask(int b, int n);
        logic [BW-1:0] m;
        for (int i = 0; i < BW; i++)
            m[i] = ((b * BW + i) < n);
        return m;
    endfunction

endpackage

// File: rtl/gpio_ctl_decode.sv
module gpio_ctl_decode
    import gpio_ctl_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_t          sel_o
);

    localparam logic [ADDR_W-1:0] WINDOW = ADDR_W'(12'h200);

    always_comb begin
        sel_o.kind = RK_NONE;
        sel_o.bank = 2'd0;
        if (addr_i < WINDOW) begin
            for (int k = 1; k < NKIND; k++) begin
                for (int b = 0; b < NBANK; b++) begin
                    if (addr_i == ADDR_W'(reg_offset(reg_kind_e'(4'(k)), b))) begin
                        sel_o.kind = reg_kind_e'(4'(k));
                        sel_o.bank = 2'(b);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/gpio_ctl_sync.sv
module gpio_ctl_sync #(
    parameter int WIDTH = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din_i,
    input  logic [WIDTH-1:0] imask_i,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] chg_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);

    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
        logic [WIDTH-1:0] pv;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.s1 = din_i & imask_i;
        s_d.s2 = s_q.s1;
        s_d.pv = s_q.s2;
        lvl_o  = s_q.s2;
        chg_o  = s_q.s2 ^ s_q.pv;
        rise_o = s_q.s2 & ~s_q.pv;
        fall_o = ~s_q.s2 & s_q.pv;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/gpio_ctl_bank.sv
module gpio_ctl_bank
    import gpio_ctl_pkg::*;
#(
    parameter logic [BW-1:0] IMPL = '1,
    parameter logic [BW-1:0] WAKE = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  reg_kind_e     kind_i,
    input  logic [BW-1:0] wdata_i,
    input  logic [BW-1:0] lvl_i,
    input  logic [BW-1:0] chg_i,
    input  logic [BW-1:0] rise_i,
    input  logic [BW-1:0] fall_i,
    output bank_view_t    view_o,
    output logic [BW-1:0] rdlvl_o,
    output logic          wake_o
);

    bank_view_t    r_d, r_q;
    logic [BW-1:0] clr_bits;
    logic [BW-1:0] listen;

    always_comb begin
        r_d      = r_q;
        clr_bits = '0;
        if (wr_i) begin
            case (kind_i)
                RK_DIR:  r_d.dir  = wdata_i;
                RK_SET:  begin
                    r_d.olat = r_q.olat | wdata_i;
                    r_d.lset = wdata_i;
                end
                RK_CLR:  r_d.olat = r_q.olat & ~wdata_i;
                RK_RISE: r_d.ren  = wdata_i;
                RK_FALL: r_d.fen  = wdata_i;
                RK_STAT: clr_bits = wdata_i;
                RK_AFLO: r_d.aflo = wdata_i;
                RK_AFHI: r_d.afhi = wdata_i;
                default: ;
            endcase
        end
        listen    = ~r_q.dir & IMPL;
        r_d.stat  = (r_q.stat & ~clr_bits)
                  | (listen & ((rise_i & r_q.ren) | (fall_i & r_q.fen)));
        wake_o    = |(chg_i & listen & WAKE);
        rdlvl_o   = (r_q.olat & r_q.dir) | (lvl_i & ~r_q.dir);
        view_o    = r_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_ctl_pkg::*;
#(
    parameter int NUM_LINES = 128,
    parameter int ADDR_W    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe,
    output logic              irq_pin0,
    output logic              irq_pin1,
    output logic              irq_other,
    output logic              wake_pulse
);

    typedef struct packed {
        logic [31:0] rdata;
        logic        wake;
    } top_t;

    reg_sel_t        dec;
    logic [NPIN-1:0] impl_all;
    logic [NPIN-1:0] lvl, chg, rise, fall;
    bank_view_t      views  [NBANK];
    logic [BW-1:0]   rdlvl  [NBANK];
    logic [NBANK-1:0] wake_hit;
    top_t            t_d, t_q;
    logic            agg;

    gpio_ctl_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i (bus_addr),
        .sel_o  (dec)
    );

    gpio_ctl_sync #(.WIDTH(NPIN)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .din_i   (pin_in),
        .imask_i (impl_all),
        .lvl_o   (lvl),
        .chg_o   (chg),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam logic [BW-1:0] IM = impl_mask(b, NUM_LINES);
        localparam logic [BW-1:0] WM = wake_mask(b);

        assign impl_all[b*BW +: BW] = IM;

        gpio_ctl_bank #(.IMPL(IM), .WAKE(WM)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_i    (bus_sel && bus_wr && (dec.bank == 2'(b))),
            .kind_i  (dec.kind),
            .wdata_i (bus_wdata),
            .lvl_i   (lvl[b*BW +: BW]),
            .chg_i   (chg[b*BW +: BW]),
            .rise_i  (rise[b*BW +: BW]),
            .fall_i  (fall[b*BW +: BW]),
            .view_o  (views[b]),
            .rdlvl_o (rdlvl[b]),
            .wake_o  (wake_hit[b])
        );

        assign pin_out[b*BW +: BW] = views[b].olat & views[b].dir & IM;
        assign pin_oe[b*BW +: BW]  = views[b].dir & IM;
    end

    always_comb begin
        agg = |views[0].stat[BW-1:2];
        for (int b = 1; b < NBANK; b++)
            agg = agg | (|views[b].stat);
    end

    always_comb begin
        t_d       = t_q;
        t_d.rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (dec.kind)
                RK_LEVEL: t_d.rdata = rdlvl[dec.bank];
                RK_DIR:   t_d.rdata = views[dec.bank].dir;
                RK_SET:   t_d.rdata = views[dec.bank].lset;
                RK_RISE:  t_d.rdata = views[dec.bank].ren;
                RK_FALL:  t_d.rdata = views[dec.bank].fen;
                RK_STAT:  t_d.rdata = views[dec.bank].stat;
                RK_AFLO:  t_d.rdata = views[dec.bank].aflo;
                RK_AFHI:  t_d.rdata = views[dec.bank].afhi;
                default:  t_d.rdata = '0;
            endcase
        end
        t_d.wake = |wake_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign bus_rdata  = t_q.rdata;
    assign wake_pulse = t_q.wake;
    assign irq_pin0   = views[0].stat[0];
    assign irq_pin1   = views[0].stat[1];
    assign irq_other  = agg;

endmodule

// File: rtl/gpio_ctl_chk.sv
module gpio_ctl_chk #(
    parameter int ADDR_W = 12,
    parameter int NPIN   = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [NPIN-1:0]   pin_out,
    input logic [NPIN-1:0]   pin_oe,
    input logic              irq_pin0
);

    // R3
    out_within_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0);

    // R3
    set_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(12'h018))
        |=> ((pin_out[31:0] & $past(bus_wdata)) == ($past(bus_wdata) & pin_oe[31:0])));

    // R3
    clr_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(12'h024))
        |=> ((pin_out[31:0] & $past(bus_wdata)) == '0));

    // R6
    irq0_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pin0 && !(bus_sel && bus_wr && bus_addr == ADDR_W'(12'h048) && bus_wdata[0]))
        |=> irq_pin0);

    // R11
    high_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr >= ADDR_W'(12'h200)) |=> (bus_rdata == '0));

    // R13
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> (bus_rdata == '0));

endmodule

bind gpio_bank_ctrl gpio_ctl_chk #(.ADDR_W(ADDR_W), .NPIN(gpio_ctl_pkg::NPIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq_pin0  (irq_pin0)
);

// File: tb/gpio_bank_ctrl_test.sv
module gpio_bank_ctrl_test;

    localparam int NL = 100;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         bus_sel, bus_wr;
    logic [11:0]  bus_addr;
    logic [31:0]  bus_wdata;
    logic [31:0]  bus_rdata;
    logic [127:0] pin_in, pin_out, pin_oe;
    logic         irq_pin0, irq_pin1, irq_other, wake_pulse;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #4 clk = ~clk;

    gpio_bank_ctrl #(.NUM_LINES(NL), .ADDR_W(12)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .irq_pin0(irq_pin0), .irq_pin1(irq_pin1), .irq_other(irq_other),
        .wake_pulse(wake_pulse)
    );

    // ---------------- reference model ----------------
    logic [31:0]  m_dir[4], m_olat[4], m_ren[4], m_fen[4], m_st[4];
    logic [31:0]  m_alo[4], m_ahi[4], m_lset[4];
    logic [127:0] m_s1, m_s2, m_pv;
    logic [31:0]  m_rdata;
    logic         m_wake;
    string        m_rtag = "R13";
    logic [127:0] implv;
    logic [31:0]  wmask[4] = '{32'h8003_FE1B, 32'h0020_01FC, 32'hEC08_0000, 32'h0012_007F};

    // code = kind*4 + bank; kinds: 1 level 2 dir 3 set 4 clr 5 rise 6 fall 7 stat 8 aflo 9 afhi
    function automatic int mdec(input logic [11:0] a);
        case (a)
            12'h000: return 4;  12'h004: return 5;  12'h008: return 6;  12'h100: return 7;
            12'h00C: return 8;  12'h010: return 9;  12'h014: return 10; 12'h10C: return 11;
            12'h018: return 12; 12'h01C: return 13; 12'h020: return 14; 12'h118: return 15;
            12'h024: return 16; 12'h028: return 17; 12'h02C: return 18; 12'h124: return 19;
            12'h030: return 20; 12'h034: return 21; 12'h038: return 22; 12'h130: return 23;
            12'h03C: return 24; 12'h040: return 25; 12'h044: return 26; 12'h13C: return 27;
            12'h048: return 28; 12'h04C: return 29; 12'h050: return 30; 12'h148: return 31;
            12'h054: return 32; 12'h05C: return 33; 12'h064: return 34; 12'h06C: return 35;
            12'h058: return 36; 12'h060: return 37; 12'h068: return 38; 12'h070: return 39;
            default: return 0;
        endcase
    endfunction

    function automatic string tagof(int kind);
        case (kind)
            1: return "R4";
            2: return "R2";
            5, 6: return "R5";
            7: return "R6";
            8, 9: return "R10";
            default: return "R11";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < 4; b++) begin
                m_dir[b] = 0; m_olat[b] = 0; m_ren[b] = 0; m_fen[b] = 0;
                m_st[b] = 0; m_alo[b] = 0; m_ahi[b] = 0; m_lset[b] = 0;
            end
            m_s1 = 0; m_s2 = 0; m_pv = 0; m_rdata = 0; m_wake = 0; m_rtag = "R1";
        end else begin
            logic [31:0] ev[4];
            logic [31:0] rd;
            logic        wk;
            int code, kk, bb;
            wk = 0;
            for (int b = 0; b < 4; b++) begin
                ev[b] = 0;
                for (int i = 0; i < 32; i++) begin
                    int p;
                    p = b * 32 + i;
                    if (p < NL && !m_dir[b][i]) begin
                        if (m_s2[p] && !m_pv[p] && m_ren[b][i]) ev[b][i] = 1;
                        if (!m_s2[p] && m_pv[p] && m_fen[b][i]) ev[b][i] = 1;
                        if (m_s2[p] != m_pv[p] && wmask[b][i]) wk = 1;
                    end
                end
            end
            code = bus_sel ? mdec(bus_addr) : 0;
            kk = code / 4;
            bb = code % 4;
            rd = 0;
            m_rtag = "R13";
            if (bus_sel && !bus_wr) begin
                m_rtag = tagof(kk);
                case (kk)
                    1: for (int i = 0; i < 32; i++)
                           rd[i] = m_dir[bb][i] ? m_olat[bb][i] : m_s2[bb*32+i];
                    2: rd = m_dir[bb];
                    3: rd = m_lset[bb];
                    5: rd = m_ren[bb];
                    6: rd = m_fen[bb];
                    7: rd = m_st[bb];
                    8: rd = m_alo[bb];
                    9: rd = m_ahi[bb];
                    default: rd = 0;
                endcase
            end
            if (bus_sel && bus_wr) begin
                case (kk)
                    2: m_dir[bb] = bus_wdata;
                    3: begin m_olat[bb] = m_olat[bb] | bus_wdata; m_lset[bb] = bus_wdata; end
                    4: m_olat[bb] = m_olat[bb] & ~bus_wdata;
                    5: m_ren[bb] = bus_wdata;
                    6: m_fen[bb] = bus_wdata;
                    7: m_st[bb] = m_st[bb] & ~bus_wdata;
                    8: m_alo[bb] = bus_wdata;
                    9: m_ahi[bb] = bus_wdata;
                    default: ;
                endcase
            end
            for (int b = 0; b < 4; b++) m_st[b] = m_st[b] | ev[b];
            m_pv = m_s2;
            m_s2 = m_s1;
            m_s1 = pin_in & implv;
            m_rdata = rd;
            m_wake = wk;
        end
    end

    // ---------------- comparison ----------------
    task automatic chk(input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    bit cmp_on = 0;
    always @(negedge clk) begin
        if (cmp_on) begin
            logic [127:0] eo, eoe;
            logic         agg;
            string        t;
            for (int b = 0; b < 4; b++) begin
                eo[b*32 +: 32]  = m_olat[b] & m_dir[b];
                eoe[b*32 +: 32] = m_dir[b];
            end
            eo  = eo & implv;
            eoe = eoe & implv;
            agg = (|m_st[0][31:2]) | (|m_st[1]) | (|m_st[2]) | (|m_st[3]);
            t = rst_n ? "" : "R1 ";
            chk({t, "R3"},  "pin_out live",  pin_out & implv, eo);
            chk({t, "R12"}, "pin_out absent", pin_out & ~implv, 128'h0);
            chk({t, "R2"},  "pin_oe",        pin_oe, eoe);
            chk({t, "R7"},  "irq_pin0",      128'(irq_pin0), 128'(m_st[0][0]));
            chk({t, "R7"},  "irq_pin1",      128'(irq_pin1), 128'(m_st[0][1]));
            chk({t, "R8"},  "irq_other",     128'(irq_other), 128'(agg));
            chk({t, "R9"},  "wake_pulse",    128'(wake_pulse), 128'(m_wake));
            chk({t, m_rtag}, "bus_rdata",    128'(bus_rdata), 128'(m_rdata));
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [11:0] a);
        bus_sel = 1; bus_wr = 0; bus_addr = a; bus_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL R13 watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    logic [11:0] offs[$];

    initial begin
        implv = (128'h1 << NL) - 1;
        rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; pin_in = 0;
        for (int a = 0; a < 'h200; a += 4)
            if (mdec(12'(a)) != 0) offs.push_back(12'(a));
        @(negedge clk);
        cmp_on = 1;
        idle(3);
        rst_n = 1;
        // R1: every register reads zero after reset
        foreach (offs[i]) rd(offs[i]);

        // R2: direction per bank, including absent pins of bank 3 (R12)
        wr(12'h00C, 32'h8000_0000);
        wr(12'h010, 32'hA5A5_5A5A);
        wr(12'h014, 32'h0000_FFFF);
        wr(12'h10C, 32'hFFFF_FFF0);
        rd(12'h00C); rd(12'h010); rd(12'h014); rd(12'h10C);

        // R3 / R11: set, clear, readback of set, clear reads zero
        wr(12'h018, 32'hF000_00F3);
        wr(12'h024, 32'h8000_0011);
        wr(12'h01C, 32'hFFFF_FFFF);
        wr(12'h028, 32'h0F0F_0F0F);
        wr(12'h118, 32'hFFFF_FFFF);
        wr(12'h124, 32'h0000_0020);
        rd(12'h018); rd(12'h024); rd(12'h118);

        // R4: level mixes latch and inputs; writes to it ignored
        pin_in = {28'hFFF_FFFF, 4'h5, 32'h1234_5678, 32'hCAFE_F00D, 32'h0F0F_F0F0};
        idle(4);
        wr(12'h000, 32'hFFFF_FFFF);
        rd(12'h000); rd(12'h004); rd(12'h008); rd(12'h100);

        // R5 / R7 / R8 / R9: edge enables
        wr(12'h00C, 32'h8000_0000);
        wr(12'h030, 32'h8000_0003);
        wr(12'h03C, 32'h0000_0010);
        wr(12'h134, 32'h0);
        wr(12'h130, 32'hFFFF_FFFF);
        wr(12'h10C, 32'h0);
        pin_in = 0;
        idle(5);
        wr(12'h048, 32'hFFFF_FFFF);
        wr(12'h148, 32'hFFFF_FFFF);
        pin_in[0] = 1; idle(4);
        pin_in[1] = 1; idle(4);
        pin_in[31] = 1; idle(4);            // output pin: no status
        pin_in[4] = 1; idle(4);
        pin_in[4] = 0; idle(4);             // falling: aggregate
        pin_in[127:96] = 32'hFFFF_FFFF; idle(4);   // R12 absent pins
        rd(12'h048); rd(12'h148);

        // R6: write-one-to-clear, clear coinciding with capture
        wr(12'h048, 32'h0000_0001);
        rd(12'h048);
        pin_in[0] = 0; idle(2);
        pin_in[0] = 1; idle(2);
        wr(12'h048, 32'h0000_0001);
        rd(12'h048);
        wr(12'h048, 32'h0000_0012);
        rd(12'h048);

        // R10: alternate-function storage
        for (int b = 0; b < 4; b++) begin
            wr(12'h054 + 12'(8*b), 32'h1111_0000 * (b + 1));
            wr(12'h058 + 12'(8*b), 32'h0000_3333 ^ (b << 20));
        end
        for (int b = 0; b < 4; b++) begin
            rd(12'h054 + 12'(8*b)); rd(12'h058 + 12'(8*b));
        end

        // R11: unmapped and out-of-window
        wr(12'h0F0, 32'hFFFF_FFFF); rd(12'h0F0);
        wr(12'h218, 32'hFFFF_FFFF); rd(12'h218);
        wr(12'h248, 32'hFFFF_FFFF); rd(12'h018);
        rd(12'h802); rd(12'h002);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = $urandom % 16;
            if (r < 5) begin
                for (int k = 0; k < 3; k++)
                    pin_in[$urandom % 128] ^= 1'b1;
                idle(1);
            end else if (r < 11) begin
                logic [31:0] d;
                d = (r == 10) ? $urandom & $urandom : $urandom;
                if ($urandom % 8 == 0) wr(12'h200 + offs[$urandom % offs.size()], d);
                else                   wr(offs[$urandom % offs.size()], d);
            end else begin
                rd(offs[$urandom % offs.size()]);
            end
        end
        idle(4);
        done = 1;
        summary();
        $finish;
    end

endmodule